// File: doc/BRIEF.md
# Microcoded Control Unit Sequencer

This block is the sequencing heart of a small 8-bit processor with a 16-bit address space. It keeps the instruction register and a micro-step counter, joins the instruction, four ALU flags, the interrupt-inhibit and interrupt-request bits and the step count into an 18-bit microcode address, and maps that address through a synthesizable microcode table to a control word. The word steers the datapath: which unit drives the address bus, whether the program counter counts, which unit drives the data bus and which one writes from it. Source and destination selections are narrow codes expanded by decoders into one-hot enables. Every instruction is a whole 8-bit code; there is no opcode/operand split.

The counter moves on the falling clock edge, so each control word settles during the low phase and is held across the rising edge where the datapath latches. The microcode is organised as a small state machine. The micro-operation states are FETCH (step 0 of every code), LOAD_LO, LOAD_HI and LOAD_ACC (steps 1 to 3 of the load-accumulator instruction) and FINISH (the clear-counter step). The transitions are: FETCH to LOAD_LO when the loaded code is the load opcode; FETCH to FINISH for any other code; LOAD_LO to LOAD_HI; LOAD_HI to LOAD_ACC; LOAD_ACC to FINISH; FINISH back to FETCH. FINISH takes no clock period, because its clear bit returns the counter to 0 at once. A hard reset puts the sequencer back at step 0 of opcode 0x00.

Top module: `cu_sequencer`

## Requirements
- R1: While `rst_n` is low, the instruction register and the step counter are cleared without waiting for a clock, so the outputs at once show the step-0 word with `seq_restart` = 0; after release, execution starts at step 0.
- R2: In step 0 the word is the same for every instruction code and every flag and interrupt value: program counter on the address bus (`pc_abus_en_n` = 0), memory on the data bus, instruction-register write, `pc_inc` = 1.
- R3: The instruction register takes `data_in` only at the rising edge inside step 0; bytes presented in later steps, even ones equal to an opcode, do not change the running instruction.
- R4: The step counter changes only at falling clock edges, so the control word sampled in the low phase equals the word sampled after the following rising edge.
- R5: Load instruction: step 1 writes the memory byte to the transfer-register low half with PC on the address bus and `pc_inc` = 1; step 2 does the same into the high half; step 3 puts the transfer register on the address bus (`xfer_abus_en_n` = 0) and writes memory data into the accumulator with `pc_inc` = 0. Never both address-bus enables low.
- R6: The step whose clear bit is set occupies no clock period: the following period shows the step-0 word with `seq_restart` = 1, and `seq_restart` is 0 in every other period.
- R7: The ALU flags and interrupt bits, though part of the microcode address, do not change the fetch, load or undefined-code sequences.
- R8: Source code k (1..15) drives `src_en_n[k-1]` low and all other source lines high; destination code k (1..7) drives `dst_we[k-1]` high and all others low; code 0 selects none. Memory is source 1; destinations are 1 instruction register, 2 transfer low, 3 transfer high, 4 accumulator.
- R9: The load opcode is the parameter `LDA_OP` (default 0xA2); any other code, 0x00 included, runs step 0 and then clears the counter in step 1, so it costs one period.
- R10: Every control line a step does not use sits at rest: active-low lines at 1, active-high lines at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; counter on falling edge, instruction register on rising edge |
| rst_n | input | 1 | Asynchronous active-low hard reset |
| data_in | input | 8 | Data-bus value offered to the instruction register |
| alu_flags | input | 4 | Zero, overflow, negative, carry flags |
| int_inhibit | input | 1 | Interrupt-inhibit state |
| int_req | input | 1 | Interrupt-request state |
| pc_abus_en_n | output | 1 | Program counter drives address bus, active low |
| xfer_abus_en_n | output | 1 | Transfer register drives address bus, active low |
| pc_inc | output | 1 | Program counter increments at the rising edge |
| src_en_n | output | 15 | One-hot active-low data-bus source enables |
| dst_we | output | 7 | One-hot active-high data-bus write strobes |
| seq_restart | output | 1 | High in the period after a counter clear |

## Verification
The bench builds the sequencer with `LDA_OP` set to 0x3C instead of its default. That turns 0xA2, the default load code, into an undefined code the bench runs, so the load decode is shown to follow the parameter and not a fixed value, while 0x3C presented as an operand byte probes that the instruction register does not reload mid-instruction. All other parameters keep their defaults, so the full 15-line source and 7-line destination decoders are exercised.

// File: rtl/cu_pkg.sv
`timescale 1ns/1ps
package cu_pkg;

    localparam int SRC_SEL_W = 4;
    localparam int DST_SEL_W = 3;
    localparam int SRC_LINES = (1 << SRC_SEL_W) - 1;
    localparam int DST_LINES = (1 << DST_SEL_W) - 1;

    typedef enum logic [1:0] {
        ABUS_NONE = 2'd0,
        ABUS_PC   = 2'd1,
        ABUS_XFER = 2'd2
    } abus_sel_e;

    localparam logic [SRC_SEL_W-1:0] SRC_NONE = 4'd0;
    localparam logic [SRC_SEL_W-1:0] SRC_MEM  = 4'd1;

    localparam logic [DST_SEL_W-1:0] DST_NONE = 3'd0;
    localparam logic [DST_SEL_W-1:0] DST_IR   = 3'd1;
    localparam logic [DST_SEL_W-1:0] DST_XLO  = 3'd2;
    localparam logic [DST_SEL_W-1:0] DST_XHI  = 3'd3;
    localparam logic [DST_SEL_W-1:0] DST_ACC  = 3'd4;

    typedef enum logic [2:0] {
        US_FETCH,
        US_LOAD_LO,
        US_LOAD_HI,
        US_LOAD_ACC,
        US_FINISH
    } ustate_e;

    typedef struct packed {
        abus_sel_e              abus;
        logic                   pc_inc;
        logic [SRC_SEL_W-1:0]   src;
        logic [DST_SEL_W-1:0]   dst;
        logic                   step_clr;
    } ctl_word_t;

    localparam ctl_word_t CTL_REST = '{
        abus: ABUS_NONE, pc_inc: 1'b0, src: SRC_NONE, dst: DST_NONE, step_clr: 1'b0
    };

endpackage

// File: rtl/cu_instr_reg.sv
`timescale 1ns/1ps
module cu_instr_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end

endmodule

// File: rtl/cu_step_ctr.sv
`timescale 1ns/1ps
module cu_step_ctr #(
    parameter int STEP_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_ahead,
    output logic [STEP_W-1:0] step_q,
    output logic              restart_q
);

    // Advances on the falling edge. When the step about to be entered
    // carries the clear bit, that step is skipped and the counter lands
    // on 0 directly, which is what an immediate clear looks like from
    // the rising edge where the datapath latches.
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_q    <= '0;
            restart_q <= 1'b0;
        end else if (clr_ahead) begin
            step_q    <= '0;
            restart_q <= 1'b1;
        end else begin
            step_q    <= step_q + 1'b1;
            restart_q <= 1'b0;
        end
    end

endmodule

// File: rtl/cu_ucode.sv
`timescale 1ns/1ps
module cu_ucode
    import cu_pkg::*;
#(
    parameter int              OP_W   = 8,
    parameter int              FLAG_W = 4,
    parameter int              STEP_W = 4,
    parameter logic [OP_W-1:0] LDA_OP = 8'hA2,
    localparam int             ADDR_W = OP_W + FLAG_W + 2 + STEP_W
) (
    input  logic [ADDR_W-1:0] uaddr,
    output ustate_e           ustate,
    output ctl_word_t         word
);

    logic [OP_W-1:0]   op;
    logic [STEP_W-1:0] step;
    logic              ctx_unused;

    assign op   = uaddr[ADDR_W-1 -: OP_W];
    assign step = uaddr[STEP_W-1:0];
    // Condition and interrupt bits form part of the address; no
    // microprogram in this table branches on them yet.
    assign ctx_unused = ^uaddr[STEP_W +: FLAG_W + 2];

    // Address to micro-operation state.
    always_comb begin
        if (step == '0) begin
            ustate = US_FETCH;
        end else if (op == LDA_OP) begin
            unique case (step)
                STEP_W'(1): ustate = US_LOAD_LO;
                STEP_W'(2): ustate = US_LOAD_HI;
                STEP_W'(3): ustate = US_LOAD_ACC;
                default:    ustate = US_FINISH;
            endcase
        end else begin
            ustate = US_FINISH;
        end
    end

    // Micro-operation state to control word.
    always_comb begin
        word = CTL_REST;
        unique case (ustate)
            US_FETCH: begin
                word.abus   = ABUS_PC;
                word.src    = SRC_MEM;
                word.dst    = DST_IR;
                word.pc_inc = 1'b1;
            end
            US_LOAD_LO: begin
                word.abus   = ABUS_PC;
                word.src    = SRC_MEM;
                word.dst    = DST_XLO;
                word.pc_inc = 1'b1;
            end
            US_LOAD_HI: begin
                word.abus   = ABUS_PC;
                word.src    = SRC_MEM;
                word.dst    = DST_XHI;
                word.pc_inc = 1'b1;
            end
            US_LOAD_ACC: begin
                word.abus   = ABUS_XFER;
                word.src    = SRC_MEM;
                word.dst    = DST_ACC;
            end
            US_FINISH: begin
                word.step_clr = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/cu_field_dec.sv
`timescale 1ns/1ps
module cu_field_dec #(
    parameter int SEL_W      = 4,
    parameter bit ACTIVE_LOW = 1'b1,
    localparam int LINES     = (1 << SEL_W) - 1
) (
    input  logic [SEL_W-1:0] sel,
    output logic [LINES-1:0] lines
);

    // Code 0 asserts nothing; code k asserts line k-1.
    for (genvar k = 0; k < LINES; k++) begin : g_line
        if (ACTIVE_LOW) begin : g_low
            assign lines[k] = (sel != SEL_W'(k + 1));
        end else begin : g_high
            assign lines[k] = (sel == SEL_W'(k + 1));
        end
    end

endmodule

// File: rtl/cu_sequencer.sv
`timescale 1ns/1ps
module cu_sequencer
    import cu_pkg::*;
#(
    parameter int              OP_W   = 8,
    parameter int              FLAG_W = 4,
    parameter int              STEP_W = 4,
    parameter logic [OP_W-1:0] LDA_OP = 8'hA2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [OP_W-1:0]      data_in,
    input  logic [FLAG_W-1:0]    alu_flags,
    input  logic                 int_inhibit,
    input  logic                 int_req,
    output logic                 pc_abus_en_n,
    output logic                 xfer_abus_en_n,
    output logic                 pc_inc,
    output logic [SRC_LINES-1:0] src_en_n,
    output logic [DST_LINES-1:0] dst_we,
    output logic                 seq_restart
);

    localparam int UADDR_W = OP_W + FLAG_W + 2 + STEP_W;

    logic [OP_W-1:0]    ir_q;
    logic [STEP_W-1:0]  step_q;
    logic [STEP_W-1:0]  step_ahead;
    logic [UADDR_W-1:0] uaddr_now;
    logic [UADDR_W-1:0] uaddr_ahead;
    ctl_word_t          word_now;
    ctl_word_t          word_ahead;
    ustate_e            state_now;
    ustate_e            state_ahead_unused;
    logic               spare_unused;

    assign step_ahead  = step_q + 1'b1;
    assign uaddr_now   = {ir_q, alu_flags, int_inhibit, int_req, step_q};
    assign uaddr_ahead = {ir_q, alu_flags, int_inhibit, int_req, step_ahead};

    cu_instr_reg #(.WIDTH(OP_W)) u_ir (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (dst_we[0]),
        .d     (data_in),
        .q     (ir_q)
    );

    cu_step_ctr #(.STEP_W(STEP_W)) u_step (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_ahead (word_ahead.step_clr),
        .step_q    (step_q),
        .restart_q (seq_restart)
    );

    cu_ucode #(
        .OP_W   (OP_W),
        .FLAG_W (FLAG_W),
        .STEP_W (STEP_W),
        .LDA_OP (LDA_OP)
    ) u_rom_now (
        .uaddr  (uaddr_now),
        .ustate (state_now),
        .word   (word_now)
    );

    cu_ucode #(
        .OP_W   (OP_W),
        .FLAG_W (FLAG_W),
        .STEP_W (STEP_W),
        .LDA_OP (LDA_OP)
    ) u_rom_ahead (
        .uaddr  (uaddr_ahead),
        .ustate (state_ahead_unused),
        .word   (word_ahead)
    );

    assign spare_unused = word_now.step_clr ^ (^word_ahead) ^ (state_now == US_FINISH);

    always_comb begin
        pc_abus_en_n   = (word_now.abus != ABUS_PC);
        xfer_abus_en_n = (word_now.abus != ABUS_XFER);
        pc_inc         = word_now.pc_inc;
    end

    cu_field_dec #(.SEL_W(SRC_SEL_W), .ACTIVE_LOW(1'b1)) u_src_dec (
        .sel   (word_now.src),
        .lines (src_en_n)
    );

    cu_field_dec #(.SEL_W(DST_SEL_W), .ACTIVE_LOW(1'b0)) u_dst_dec (
        .sel   (word_now.dst),
        .lines (dst_we)
    );

endmodule

// File: rtl/cu_sequencer_chk.sv
`timescale 1ns/1ps
module cu_sequencer_chk #(
    parameter int STEP_W    = 4,
    parameter int SRC_LINES = 15,
    parameter int DST_LINES = 7
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 pc_abus_en_n,
    input logic                 xfer_abus_en_n,
    input logic                 pc_inc,
    input logic [SRC_LINES-1:0] src_en_n,
    input logic [DST_LINES-1:0] dst_we,
    input logic                 seq_restart,
    input logic [STEP_W-1:0]    step_q
);

    AST_SRC_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(~src_en_n)); // R8
    AST_DST_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(dst_we)); // R8
    AST_ABUS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) (pc_abus_en_n || xfer_abus_en_n)); // R5
    AST_IR_LOAD_STEP0: assert property (@(posedge clk) disable iff (!rst_n) dst_we[0] |-> (step_q == '0)); // R3
    AST_STEP0_FETCH: assert property (@(posedge clk) disable iff (!rst_n) (step_q == '0) |-> (dst_we[0] && !pc_abus_en_n && pc_inc)); // R2
    AST_RESTART_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n) seq_restart |-> (step_q == '0)); // R6

endmodule

bind cu_sequencer cu_sequencer_chk #(
    .STEP_W    (STEP_W),
    .SRC_LINES (cu_pkg::SRC_LINES),
    .DST_LINES (cu_pkg::DST_LINES)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .pc_abus_en_n   (pc_abus_en_n),
    .xfer_abus_en_n (xfer_abus_en_n),
    .pc_inc         (pc_inc),
    .src_en_n       (src_en_n),
    .dst_we         (dst_we),
    .seq_restart    (seq_restart),
    .step_q         (step_q)
);

// File: tb/tb_cu_sequencer.sv
`timescale 1ns/1ps
module tb_cu_sequencer;

    localparam logic [7:0] OP_LOAD = 8'h3C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  data_in = 8'h00;
    logic [3:0]  alu_flags = 4'h0;
    logic        int_inhibit = 1'b0;
    logic        int_req = 1'b0;
    logic        pc_abus_en_n, xfer_abus_en_n, pc_inc, seq_restart;
    logic [14:0] src_en_n;
    logic [6:0]  dst_we;

    int checks = 0;
    int fails = 0;
    bit ended = 1'b0;
    logic [25:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    cu_sequencer #(.LDA_OP(OP_LOAD)) dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .data_in        (data_in),
        .alu_flags      (alu_flags),
        .int_inhibit    (int_inhibit),
        .int_req        (int_req),
        .pc_abus_en_n   (pc_abus_en_n),
        .xfer_abus_en_n (xfer_abus_en_n),
        .pc_inc         (pc_inc),
        .src_en_n       (src_en_n),
        .dst_we         (dst_we),
        .seq_restart    (seq_restart)
    );

    // Expected words: {pc_abus_en_n, xfer_abus_en_n, pc_inc, src_en_n, dst_we, seq_restart}
    // Memory is source 1 -> src_en_n[0] low (R8).
    function automatic logic [25:0] w_fetch(bit rs);
        return {1'b0, 1'b1, 1'b1, 15'h7FFE, 7'b0000001, rs};
    endfunction
    localparam logic [25:0] W_LO  = {1'b0, 1'b1, 1'b1, 15'h7FFE, 7'b0000010, 1'b0};
    localparam logic [25:0] W_HI  = {1'b0, 1'b1, 1'b1, 15'h7FFE, 7'b0000100, 1'b0};
    localparam logic [25:0] W_ACC = {1'b1, 1'b0, 1'b0, 15'h7FFE, 7'b0001000, 1'b0};

    function automatic logic [25:0] outs();
        return {pc_abus_en_n, xfer_abus_en_n, pc_inc, src_en_n, dst_we, seq_restart};
    endfunction

    task automatic check(string tag, logic [25:0] got, logic [25:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // Driver: one clock period, starting just after the falling edge.
    task automatic step(logic [7:0] d, logic [3:0] fl, logic ii, logic irq,
                        logic [25:0] exp, string tag, bit rel);
        @(negedge clk);
        #1;
        if (rel) rst_n = 1'b1;
        data_in     = d;
        alu_flags   = fl;
        int_inhibit = ii;
        int_req     = irq;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
    endtask

    task automatic run_load(logic [7:0] lo, logic [7:0] hi, logic [3:0] fl,
                            logic ii, logic irq, string tag, bit rel);
        step(OP_LOAD, fl, ii, irq, w_fetch(ended), {tag, " R2 R6 fetch"}, rel);
        step(lo, fl, ii, irq, W_LO, {tag, " R5 R3 step1"}, 1'b0);
        step(hi, fl, ii, irq, W_HI, {tag, " R5 step2"}, 1'b0);
        step(8'h5A, fl, ii, irq, W_ACC, {tag, " R5 R10 step3"}, 1'b0);
        ended = 1'b1;
    endtask

    task automatic run_undef(logic [7:0] op, logic [3:0] fl, string tag);
        step(op, fl, fl[0], fl[1], w_fetch(ended), {tag, " R9 R6 fetch"}, 1'b0);
        ended = 1'b1;
    endtask

    // Monitor: low-phase sample, then a second sample after the rising edge (R4).
    initial begin
        forever begin
            @(negedge clk);
            #3;
            if (exp_q.size() != 0) begin
                automatic logic [25:0] e = exp_q.pop_front();
                automatic string       t = tag_q.pop_front();
                check({t, " low"}, outs(), e);
                #4;
                check({t, " R4 high"}, outs(), e);
            end
        end
    end

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #3;
        check("R1 reset state", outs(), w_fetch(1'b0));

        run_load(OP_LOAD, 8'hA2, 4'h0, 1'b0, 1'b0, "R3 opcode-valued operand", 1'b1);
        run_load(8'h08, 8'h00, 4'hF, 1'b1, 1'b1, "R7 all flags set", 1'b0);
        run_undef(8'hA2, 4'h5, "R9 default code now undefined");
        run_undef(8'h00, 4'hA, "R9 zero code");
        run_undef(8'hFF, 4'h3, "R9 all-ones code");
        run_load(8'h34, 8'h12, 4'h0, 1'b0, 1'b0, "R6 load after undefined", 1'b0);
        for (int f = 0; f < 16; f += 3) begin
            run_load(8'(f), 8'(f * 7), 4'(f), f[0], f[1], "R7 flag sweep", 1'b0);
        end
        run_undef(8'h81, 4'h9, "R9 undefined after load");

        // Hard reset in the middle of a load instruction.
        step(OP_LOAD, 4'h0, 1'b0, 1'b0, w_fetch(ended), "R1 pre-reset fetch", 1'b0);
        step(8'h77, 4'h0, 1'b0, 1'b0, W_LO, "R1 pre-reset step1", 1'b0);
        @(posedge clk);
        #3;
        rst_n = 1'b0;
        #1;
        check("R1 asynchronous clear", outs(), w_fetch(1'b0));
        ended = 1'b0;
        run_load(8'h11, 8'h22, 4'h6, 1'b0, 1'b1, "R1 after release", 1'b1);
        run_undef(8'h3D, 4'h0, "R9 neighbour of load code");
        run_load(8'hFE, 8'hFF, 4'h1, 1'b1, 1'b0, "R5 final load", 1'b0);

        repeat (3) @(negedge clk);
        #10;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule